// File: doc/BRIEF.md
# Parallel-load shift register with set/clear/toggle entry stage

This block is a chain of `WIDTH` flip-flops (four by default) that on every rising clock edge either loads all stages from a parallel data bus or shifts the chain by one position toward the most significant stage. A single active-low mode input chooses between the two. In shift mode the entry stage (bit 0) does not simply take a serial bit. It is driven by a pair of controls, an active-high `j_in` and an active-low `k_n`, and this pair sets, clears, toggles or holds that stage. When `j_in` and `k_n` are tied together, the entry stage behaves as a plain serial data input.

The outputs are all stage values and a separate copy of the last stage in inverted form. An active-low asynchronous reset clears the whole chain at once. The register is used for serial-to-parallel and parallel-to-serial conversion. It also suits small state sequences that need the entry stage to toggle or hold. Shifting in the opposite direction is possible with outside wiring: connect each output to the parallel input one position below and keep the block in load mode.

Top module: `jkshift_reg`

## Requirements
- R1: Stage values change only on a rising edge of `clk` or on assertion of `rst_n`. A change on `load_n`, `j_in`, `k_n` or `par_d` between edges leaves `q` unchanged.
- R2: With `load_n` = 0 at a rising edge, `q[i]` takes `par_d[i]` for every stage i, whatever `j_in` and `k_n` are.
- R3: With `load_n` = 1 at a rising edge, `q[i]` takes the previous `q[i-1]` for every i from 1 to `WIDTH`-1, whatever `j_in` and `k_n` are.
- R4: In shift mode with `j_in` = 1 and `k_n` = 1, `q[0]` becomes 1.
- R5: In shift mode with `j_in` = 0 and `k_n` = 0, `q[0]` becomes 0.
- R6: In shift mode with `j_in` = 1 and `k_n` = 0, `q[0]` becomes the complement of its previous value.
- R7: In shift mode with `j_in` = 0 and `k_n` = 1, `q[0]` keeps its previous value.
- R8: While `rst_n` = 0, every stage reads 0 without waiting for a clock edge, and a load or shift at a clock edge has no effect. `q_last_n` then reads 1.
- R9: `q_last_n` always equals the inverse of `q[WIDTH-1]`.
- R10: After `rst_n` returns to 1, the first rising edge already performs a normal load or shift. There is no extra idle cycle.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all loads and shifts happen on its rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | 0 = parallel load, 1 = shift toward the most significant stage |
| j_in | input | 1 | Entry-stage set control, active high |
| k_n | input | 1 | Entry-stage clear control, active low |
| par_d | input | WIDTH | Parallel data, one bit per stage |
| q | output | WIDTH | Stage values, bit 0 is the entry stage |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
The in-module properties check on every clocked cycle out of reset that a load copies the parallel bus and that a shift moves each stage up by one. They also check that each of the four `j_in`/`k_n` codes gives the correct entry-stage result. Only the bench scenarios show the asynchronous side of reset: stages clearing between edges, a load that is blocked while reset is held, and the first edge after release taking effect. The bench scenarios also cover the insensitivity to mid-cycle input changes and the inverted last-stage output, which the bench compares against the stage value after every step.

// File: rtl/jkshift_pkg.sv
// Package: shared types for the JK-fed shift register.
// Assumes: nothing beyond IEEE 1800-2017.
package jkshift_pkg;

    // Entry-stage action selected by the {j_in, k_n} pair in shift mode.
    typedef enum logic [1:0] {
        JK_CLEAR  = 2'b00,
        JK_HOLD   = 2'b01,
        JK_TOGGLE = 2'b10,
        JK_SET    = 2'b11
    } jk_action_e;

    // Map the raw control pair to its action code.
    function automatic jk_action_e jk_decode(input logic j, input logic kn);
        return jk_action_e'({j, kn});
    endfunction

endpackage

// File: rtl/jkshift_head.sv
// Module: jkshift_head
// Computes the next value of the entry stage in shift mode from the
// set control, the active-low clear control and the current value.
// Assumes: the caller applies the result only when shifting.
module jkshift_head
    import jkshift_pkg::*;
(
    input  logic j_in,
    input  logic k_n,
    input  logic cur,
    output logic nxt
);

    jk_action_e action;

    // Decode the control pair and pick the entry-stage result.
    always_comb begin
        action = jk_decode(j_in, k_n);
        case (action)
            JK_SET:    nxt = 1'b1;
            JK_CLEAR:  nxt = 1'b0;
            JK_TOGGLE: nxt = ~cur;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/jkshift_next.sv
// Module: jkshift_next
// Forms the next-state vector of the whole chain: the parallel bus in
// load mode, otherwise the chain moved up by one with the head bit
// placed in stage 0.
// Assumes: WIDTH >= 2.
module jkshift_next #(
    parameter int WIDTH = 4
) (
    input  logic             load_n,
    input  logic             head_bit,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] nxt
);

    // Entry stage: load or head result.
    always_comb nxt[0] = load_n ? head_bit : par_d[0];

    // Remaining stages: load or take the stage below.
    for (genvar i = 1; i < WIDTH; i++) begin : g_stage
        always_comb nxt[i] = load_n ? cur[i-1] : par_d[i];
    end

endmodule

// File: rtl/jkshift_reg.sv
// Module: jkshift_reg (top)
// WIDTH-stage register that loads in parallel or shifts toward the MSB
// on each rising clock edge; the entry stage is fed by a set / active-low
// clear pair. Also drives the inverse of the last stage.
// Assumes: rst_n is an asynchronous active-low clear; WIDTH >= 2.
module jkshift_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             j_in,
    input  logic             k_n,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] q,
    output logic             q_last_n
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] stage_d;
    logic             head_nxt;

    jkshift_head u_head (
        .j_in (j_in),
        .k_n  (k_n),
        .cur  (stage_q[0]),
        .nxt  (head_nxt)
    );

    jkshift_next #(.WIDTH(WIDTH)) u_next (
        .load_n   (load_n),
        .head_bit (head_nxt),
        .cur      (stage_q),
        .par_d    (par_d),
        .nxt      (stage_d)
    );

    // Stage registers: asynchronous clear, update on rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    // Output drive: stage values and inverted last stage.
    always_comb begin
        q        = stage_q;
        q_last_n = ~stage_q[MSB];
    end

    // R2: a load copies the parallel bus.
    a_r2_load_copies_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(par_d));

    // R3: a shift moves every upper stage up by one.
    a_r3_shift_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> q[MSB:1] == $past(q[MSB-1:0]));

    // R4: set code forces the entry stage high.
    a_r4_entry_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && j_in && k_n) |=> q[0]);

    // R5: clear code forces the entry stage low.
    a_r5_entry_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !j_in && !k_n) |=> !q[0]);

    // R6: toggle code inverts the entry stage.
    a_r6_entry_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && j_in && !k_n) |=> q[0] != $past(q[0]));

    // R7: hold code keeps the entry stage.
    a_r7_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !j_in && k_n) |=> $stable(q[0]));

endmodule

// File: tb/jkshift_reg_tb.sv
`timescale 1ns/100ps
module jkshift_reg_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         load_n;
    logic         j_in;
    logic         k_n;
    logic [W-1:0] par_d;
    logic [W-1:0] q;
    logic         q_last_n;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    jkshift_reg #(.WIDTH(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .j_in     (j_in),
        .k_n      (k_n),
        .par_d    (par_d),
        .q        (q),
        .q_last_n (q_last_n)
    );

    always #2 clk = ~clk;

    // Vector: {load_n, j_in, k_n, par_d[3:0], expected q[3:0]}
    localparam int NV = 13;
    localparam logic [10:0] VEC [NV] = '{
        {3'b0_0_0, 4'b1010, 4'b1010},   // R2 load
        {3'b1_1_1, 4'b0000, 4'b0101},   // R4 set + R3 shift
        {3'b1_1_0, 4'b1111, 4'b1010},   // R6 toggle 1->0
        {3'b1_1_0, 4'b0000, 4'b0101},   // R6 toggle 0->1
        {3'b1_0_1, 4'b0000, 4'b1011},   // R7 hold 1
        {3'b1_0_0, 4'b1111, 4'b0110},   // R5 clear
        {3'b1_0_1, 4'b1111, 4'b1100},   // R7 hold 0
        {3'b0_1_0, 4'b0111, 4'b0111},   // R2 load, J/K ignored
        {3'b1_0_0, 4'b0000, 4'b1110},   // R5 clear
        {3'b1_1_1, 4'b0000, 4'b1101},   // R4 set
        {3'b0_1_1, 4'b0000, 4'b0000},   // R2 load zero
        {3'b1_1_0, 4'b1010, 4'b0001},   // R6 toggle
        {3'b0_0_1, 4'b1111, 4'b1111}    // R2 load ones
    };

    task automatic check(input string req, input logic [W-1:0] exp_q);
        n_run++;
        if (q !== exp_q || q_last_n !== ~exp_q[W-1]) begin
            n_fail++;
            $display("FAIL %s: q=%b q_last_n=%b expected q=%b q_last_n=%b",
                     req, q, q_last_n, exp_q, ~exp_q[W-1]);
        end
    endtask

    task automatic step(input logic ld, input logic j, input logic kn,
                        input logic [W-1:0] d);
        @(negedge clk);
        load_n = ld; j_in = j; k_n = kn; par_d = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0; load_n = 1'b1; j_in = 1'b0; k_n = 1'b1; par_d = '0;
        @(posedge clk); @(posedge clk); #1;
        check("R8 reset state", 4'b0000);
        @(negedge clk); rst_n = 1'b1;

        // Table walk: R2..R7, R9 via q_last_n in every check.
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
            check($sformatf("R2-7 vec %0d", i), VEC[i][3:0]);
        end

        // R1: inputs change mid-cycle, q must not move before the edge.
        #0.5;
        load_n = 1'b0; par_d = 4'b0010; j_in = 1'b0; k_n = 1'b0;
        #0.5;
        check("R1 no change between edges", 4'b1111);

        // R8: mid-cycle async clear.
        @(posedge clk); #1;                 // load 0010 happens here
        check("R2 load before reset", 4'b0010);
        rst_n = 1'b0;
        #0.5;
        check("R8 async clear mid-cycle", 4'b0000);

        // R8: reset held with a load pending across an edge.
        @(negedge clk); load_n = 1'b0; par_d = 4'b1001;
        @(posedge clk); #1;
        check("R8 load blocked under reset", 4'b0000);

        // R10: release, first edge loads.
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R10 first edge after release", 4'b1001);

        // R9: last stage high -> inverted output low, then shift it out.
        step(1'b1, 1'b0, 1'b0, 4'b0000);
        check("R9 inverted last stage", 4'b0010);

        // D-style entry: J and K_n tied.
        step(1'b1, 1'b1, 1'b1, 4'b0000);
        check("R4 tied J/K_n as data 1", 4'b0101);
        step(1'b1, 1'b0, 1'b0, 4'b0000);
        check("R5 tied J/K_n as data 0", 4'b1010);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule